// File: doc/BRIEF.md
# Miscellaneous Runtime Register Bank for a Peripheral I/O Hub

This block is a byte-wide register bank with four registers at consecutive offsets of a simple host bus. The bus has an address, write data, a write strobe, a read strobe and read data. Two of the registers are live state. The first holds a status latch for each of two general-purpose inputs. A latch sets on either edge of its input, and software clears it by writing a one to its bit. The second holds a floppy disk-change override flag. Software can set this flag but cannot clear it. The flag clears itself when the drive steps while drive 0 is selected.

The other two registers are read-only shadows. Two elsewhere registers are write-only: the floppy data-rate select register and the UART FIFO control register. The host bus write data is routed to those registers as well, and a strobe for each one tells this block when that register is written. On that strobe, the matching shadow captures the byte so software can read back what was last written.

The block also drives the disk-change indication seen by the floppy controller. This output combines the override flag, the drive-0 select and the external disk-change input.

The override flag is held by a two-state machine. Its states are FRC_ACTIVE, the reset state with the flag set, and FRC_CLEAR, with the flag clear. The machine has two transitions. FRC_CLEAR goes to FRC_ACTIVE on a host write to offset 1 with data bit 0 at one, unless a hardware clear occurs in the same cycle. FRC_ACTIVE goes to FRC_CLEAR on a hardware clear, which is a cycle where the step strobe and the drive-0 select are both low.

Top module: `sio_misc_regs`

## Requirements
- R1: After reset the reads are as follows. Offset 0 (edge status) reads 0x00. Offset 1 (disk-change override) reads 0x01. Offsets 2 and 3 (shadows) read 0x00.
- R2: A rising or falling edge on `gp_in[i]` sets status bit i at offset 0. The bit is readable as set no more than 4 clock cycles after the input changes. The input first passes through a two-flop synchronizer.
- R3: A host write to offset 0 clears each status bit i whose data bit i is 1. A data bit of 0 leaves its status bit unchanged. Status bits 7:2 always read 0.
- R4: If an input edge is detected in the same cycle as a write-one-to-clear of its bit, the status bit stays set.
- R5: A host write to offset 1 with data bit 0 at 1 sets the override flag, which reads at bit 0. Writing data bit 0 at 0 has no effect. Bits 7:1 of offset 1 always read 0.
- R6: The override flag is cleared in any cycle where `step_n` and `ds0_n` are both low. Either signal low by itself does not clear the flag. A hardware clear wins over a host set in the same cycle.
- R7: `dskchg_out` (active high) equals (not `ds0_n` AND the override flag) OR (not `dskchg_n`). It is combinational.
- R8: A pulse on `rate_wr` loads `host_wdata` into the data-rate shadow at offset 2. The shadow layout is: bits 1:0 rate select, bits 4:2 precompensation, bit 6 power down, bit 7 soft reset. Reserved bit 5 reads 0. Host writes to offset 2 are ignored.
- R9: A pulse on `fifo_wr` loads `host_wdata` into the FIFO-control shadow at offset 3. The shadow layout is: bit 0 enable, bit 1 receive reset, bit 2 transmit reset, bit 3 DMA mode, bits 7:6 receive trigger. Reserved bits 5:4 read 0. Host writes to offset 3 are ignored.
- R10: Reads at offsets 4 to 7 return 0x00, and writes there change no register. Read data is 0x00 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low main power-on reset |
| host_addr | input | ADDR_W (3) | Register offset |
| host_wdata | input | 8 | Write data; also the data for the shadow strobes |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, combinational while `host_rd` is high |
| rate_wr | input | 1 | Strobe: data-rate register written elsewhere |
| fifo_wr | input | 1 | Strobe: UART FIFO control register written elsewhere |
| gp_in | input | N_GP (2) | Asynchronous general-purpose edge inputs |
| step_n | input | 1 | Drive step strobe, active low |
| ds0_n | input | 1 | Drive 0 select, active low |
| dskchg_n | input | 1 | External disk-change input, active low |
| dskchg_out | output | 1 | Disk-change indication to the floppy controller, active high |

## Verification
A stuck or wrong FRC state shows up at once on `dskchg_out` whenever drive 0 is selected. It is also visible at bit 0 of offset 1 on the next read. A lost or spurious status latch is visible at offset 0 within four cycles of the input edge. The bench lines up a write-one-to-clear exactly with the cycle in which the edge is detected, which exposes a clear that wrongly takes priority over the edge. A shadow that loads from the wrong strobe, or that keeps a reserved bit, shows up on the first read-back after a strobe carrying an all-ones byte.

// File: rtl/sio_misc_pkg.sv
package sio_misc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OFS_STATUS = 2'd0,
        OFS_FORCE  = 2'd1,
        OFS_RATE   = 2'd2,
        OFS_FIFO   = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        FRC_CLEAR  = 1'b0,
        FRC_ACTIVE = 1'b1
    } frc_state_e;

    localparam logic [BYTE_W-1:0] RATE_MASK = 8'hDF;
    localparam logic [BYTE_W-1:0] FIFO_MASK = 8'hCF;
endpackage

// File: rtl/gp_edge_det.sv
module gp_edge_det #(
    parameter int N_GP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_GP-1:0] gp_in,
    output logic [N_GP-1:0] edge_o
);
    localparam int PRIME_W = 3;

    // Edges are reported only after the whole chain holds real samples.
    logic [PRIME_W-1:0] prime_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prime_q <= '0;
        else        prime_q <= {prime_q[PRIME_W-2:0], 1'b1};
    end

    for (genvar g = 0; g < N_GP; g++) begin : g_chan
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= gp_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign edge_o[g] = prime_q[PRIME_W-1] & (sync_q ^ prev_q);
    end
endmodule

// File: rtl/status_w1c.sv
module status_w1c #(
    parameter int N_GP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_GP-1:0] set_i,
    input  logic [N_GP-1:0] clr_i,
    output logic [N_GP-1:0] st_o
);
    logic [N_GP-1:0] st_q;

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_i) | set_i;
    end

    assign st_o = st_q;
endmodule

// File: rtl/force_chg_fsm.sv
module force_chg_fsm
    import sio_misc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set_i,
    input  logic hw_clr_i,
    output logic flag_o
);
    frc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FRC_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRC_CLEAR:  if (sw_set_i && !hw_clr_i) state_d = FRC_ACTIVE;
            FRC_ACTIVE: if (hw_clr_i)              state_d = FRC_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FRC_ACTIVE);
    end
endmodule

// File: rtl/shadow_reg.sv
module shadow_reg #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_q <= '0;
        else if (ld_i) q_q <= d_i & MASK;
    end

    assign q_o = q_q;
endmodule

// File: rtl/sio_misc_regs.sv
module sio_misc_regs
    import sio_misc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int N_GP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              rate_wr,
    input  logic              fifo_wr,
    input  logic [N_GP-1:0]   gp_in,
    input  logic              step_n,
    input  logic              ds0_n,
    input  logic              dskchg_n,
    output logic              dskchg_out
);
    localparam int PAD_W = BYTE_W - N_GP;

    logic              in_window;
    reg_ofs_e          ofs;
    logic [N_GP-1:0]   gp_edge;
    logic [N_GP-1:0]   status_q;
    logic [N_GP-1:0]   status_clr;
    logic              force_flag;
    logic              force_set;
    logic              hw_clr;
    logic [BYTE_W-1:0] rate_q;
    logic [BYTE_W-1:0] fifo_q;

    assign in_window  = ((host_addr >> 2) == '0);
    assign ofs        = reg_ofs_e'(host_addr[1:0]);
    assign status_clr = (host_wr && in_window && ofs == OFS_STATUS)
                        ? host_wdata[N_GP-1:0] : '0;
    assign force_set  = host_wr && in_window && ofs == OFS_FORCE && host_wdata[0];
    assign hw_clr     = !step_n && !ds0_n;

    gp_edge_det #(.N_GP(N_GP)) u_edge (
        .clk(clk), .rst_n(rst_n), .gp_in(gp_in), .edge_o(gp_edge)
    );

    status_w1c #(.N_GP(N_GP)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(gp_edge), .clr_i(status_clr),
        .st_o(status_q)
    );

    force_chg_fsm u_force (
        .clk(clk), .rst_n(rst_n), .sw_set_i(force_set), .hw_clr_i(hw_clr),
        .flag_o(force_flag)
    );

    shadow_reg #(.W(BYTE_W), .MASK(RATE_MASK)) u_rate (
        .clk(clk), .rst_n(rst_n), .ld_i(rate_wr), .d_i(host_wdata), .q_o(rate_q)
    );

    shadow_reg #(.W(BYTE_W), .MASK(FIFO_MASK)) u_fifo (
        .clk(clk), .rst_n(rst_n), .ld_i(fifo_wr), .d_i(host_wdata), .q_o(fifo_q)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd && in_window) begin
            unique case (ofs)
                OFS_STATUS: host_rdata = {{PAD_W{1'b0}}, status_q};
                OFS_FORCE:  host_rdata = {{(BYTE_W-1){1'b0}}, force_flag};
                OFS_RATE:   host_rdata = rate_q;
                OFS_FIFO:   host_rdata = fifo_q;
            endcase
        end
    end

    assign dskchg_out = (!ds0_n && force_flag) || !dskchg_n;
endmodule

module sio_misc_chk #(
    parameter int ADDR_W = 3,
    parameter int N_GP   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_rdata,
    input logic              rate_wr,
    input logic              fifo_wr,
    input logic              step_n,
    input logic              ds0_n,
    input logic              dskchg_n,
    input logic              dskchg_out,
    input logic [N_GP-1:0]   gp_edge,
    input logic [N_GP-1:0]   status_q,
    input logic              force_flag,
    input logic [7:0]        rate_q,
    input logic [7:0]        fifo_q
);
    logic win;
    assign win = ((host_addr >> 2) == '0);

    for (genvar g = 0; g < N_GP; g++) begin : g_st
        // R3: a one written clears the bit when no edge competes
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && win && host_addr[1:0] == 2'd0 && host_wdata[g] && !gp_edge[g])
            |=> !status_q[g]);
        // R4 and R2: a detected edge always leaves the bit set
        a_r4_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            gp_edge[g] |=> status_q[g]);
    end

    a_r3_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && win && host_addr[1:0] == 2'd0) |-> host_rdata[7:N_GP] == '0);

    a_r5_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && win && host_addr[1:0] == 2'd1 && host_wdata[0] && step_n)
        |=> force_flag);

    a_r6_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_n && !ds0_n) |=> !force_flag);

    a_r7_ext_chg: assert property (@(posedge clk) disable iff (!rst_n)
        !dskchg_n |-> dskchg_out);

    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ds0_n && dskchg_n) |-> !dskchg_out);

    a_r8_rate_load: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> rate_q == ($past(host_wdata) & 8'hDF));

    a_r8_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr |=> $stable(rate_q));

    a_r9_fifo_load: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> fifo_q == ($past(host_wdata) & 8'hCF));

    a_r9_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_wr |=> $stable(fifo_q));

    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd || !win) |-> host_rdata == 8'h00);
endmodule

bind sio_misc_regs sio_misc_chk #(.ADDR_W(ADDR_W), .N_GP(N_GP)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .rate_wr(rate_wr), .fifo_wr(fifo_wr), .step_n(step_n), .ds0_n(ds0_n),
    .dskchg_n(dskchg_n), .dskchg_out(dskchg_out), .gp_edge(gp_edge),
    .status_q(status_q), .force_flag(force_flag), .rate_q(rate_q), .fifo_q(fifo_q)
);

// File: tb/sim_sio_misc_regs.sv
`timescale 1ns/1ps
module sim_sio_misc_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       rate_wr = 1'b0, fifo_wr = 1'b0;
    logic [1:0] gp_in = '0;
    logic       step_n = 1'b1, ds0_n = 1'b1, dskchg_n = 1'b1;
    logic       dskchg_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_misc_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .rate_wr(rate_wr), .fifo_wr(fifo_wr), .gp_in(gp_in), .step_n(step_n),
        .ds0_n(ds0_n), .dskchg_n(dskchg_n), .dskchg_out(dskchg_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        host_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        expect_reg("R1 status reset", 3'd0, 8'h00);
        expect_reg("R1 override reset", 3'd1, 8'h01);
        expect_reg("R1 rate shadow reset", 3'd2, 8'h00);
        expect_reg("R1 fifo shadow reset", 3'd3, 8'h00);
        check("R10 idle rdata", host_rdata, 8'h00);
    endtask

    task automatic t_edges();
        @(negedge clk) gp_in[0] = 1'b1;
        settle();
        expect_reg("R2 rising edge gp0", 3'd0, 8'h01);
        host_write(3'd0, 8'h01);
        expect_reg("R3 w1c clears bit0", 3'd0, 8'h00);
        @(negedge clk) gp_in[0] = 1'b0;
        settle();
        expect_reg("R2 falling edge gp0", 3'd0, 8'h01);
        @(negedge clk) gp_in[1] = 1'b1;
        settle();
        expect_reg("R2 rising edge gp1", 3'd0, 8'h03);
        host_write(3'd0, 8'h00);
        expect_reg("R3 write zero no effect", 3'd0, 8'h03);
        host_write(3'd0, 8'hFE);
        expect_reg("R3 clear bit1 only", 3'd0, 8'h01);
        host_write(3'd0, 8'hFF);
        expect_reg("R3 clear all", 3'd0, 8'h00);
    endtask

    task automatic t_collide();
        // Input changes before edge k; the edge is detected and latched at edge k+2.
        @(negedge clk) gp_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 8'h01; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        expect_reg("R4 edge wins over clear", 3'd0, 8'h01);
        host_write(3'd0, 8'h01);
        expect_reg("R4 later clear works", 3'd0, 8'h00);
    endtask

    task automatic t_force();
        @(negedge clk); #1;
        check("R7 not selected, out low", {7'd0, dskchg_out}, 8'h00);
        ds0_n = 1'b0; #1;
        check("R7 selected with flag, out high", {7'd0, dskchg_out}, 8'h01);
        @(negedge clk) step_n = 1'b0;
        @(negedge clk) step_n = 1'b1; #1;
        check("R6 step+select clears, out low", {7'd0, dskchg_out}, 8'h00);
        ds0_n = 1'b1;
        expect_reg("R6 flag cleared", 3'd1, 8'h00);
        host_write(3'd1, 8'h00);
        expect_reg("R5 write zero keeps clear", 3'd1, 8'h00);
        host_write(3'd1, 8'hFF);
        expect_reg("R5 set, upper bits zero", 3'd1, 8'h01);
        host_write(3'd1, 8'h00);
        expect_reg("R5 write zero cannot clear", 3'd1, 8'h01);
        @(negedge clk) step_n = 1'b0;
        @(negedge clk) step_n = 1'b1;
        expect_reg("R6 step alone no clear", 3'd1, 8'h01);
        @(negedge clk) ds0_n = 1'b0;
        @(negedge clk) ds0_n = 1'b1;
        expect_reg("R6 select alone no clear", 3'd1, 8'h01);
        @(negedge clk) begin step_n = 1'b0; ds0_n = 1'b0; end
        @(negedge clk) begin step_n = 1'b1; ds0_n = 1'b1; end
        @(negedge clk);
        host_addr = 3'd1; host_wdata = 8'h01; host_wr = 1'b1;
        step_n = 1'b0; ds0_n = 1'b0;
        @(negedge clk);
        host_wr = 1'b0; step_n = 1'b1; ds0_n = 1'b1;
        expect_reg("R6 clear wins over set", 3'd1, 8'h00);
        @(negedge clk) dskchg_n = 1'b0; #1;
        check("R7 external change, out high", {7'd0, dskchg_out}, 8'h01);
        dskchg_n = 1'b1; #1;
        check("R7 external released, out low", {7'd0, dskchg_out}, 8'h00);
    endtask

    task automatic snoop(input bit which, input logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        if (which) fifo_wr = 1'b1; else rate_wr = 1'b1;
        @(negedge clk);
        rate_wr = 1'b0; fifo_wr = 1'b0;
    endtask

    task automatic t_shadow();
        snoop(1'b0, 8'hFF);
        expect_reg("R8 rate shadow bit5 zero", 3'd2, 8'hDF);
        host_write(3'd2, 8'h00);
        expect_reg("R8 host write ignored", 3'd2, 8'hDF);
        snoop(1'b0, 8'hA5);
        expect_reg("R8 rate shadow pattern", 3'd2, 8'h85);
        snoop(1'b1, 8'hFF);
        expect_reg("R9 fifo shadow bits5:4 zero", 3'd3, 8'hCF);
        snoop(1'b1, 8'h81);
        expect_reg("R9 fifo shadow pattern", 3'd3, 8'h81);
        host_write(3'd3, 8'h4E);
        expect_reg("R9 host write ignored", 3'd3, 8'h81);
        expect_reg("R8 rate kept on fifo strobe", 3'd2, 8'h85);
    endtask

    task automatic t_unmapped();
        for (int a = 4; a < 8; a++) host_write(3'(a), 8'hFF);
        for (int a = 4; a < 8; a++) expect_reg("R10 unmapped read", 3'(a), 8'h00);
        expect_reg("R10 status untouched", 3'd0, 8'h00);
        expect_reg("R10 override untouched", 3'd1, 8'h00);
        expect_reg("R10 rate untouched", 3'd2, 8'h85);
        expect_reg("R10 fifo untouched", 3'd3, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_edges();
        t_collide();
        t_force();
        t_shadow();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule